// File: doc/BRIEF.md
# Receive Buffer Hysteresis Throttle

This block decides when a serial receiver must ask its link partner to pause and when it may let it continue. It reads the occupancy count of a 64-entry receive buffer and compares it against two programmable levels taken from one 8-bit configuration byte. The pause level comes from the lower four bits and the continue level from the upper four bits, each scaled by four. A single throttle bit is set when the count reaches the pause level and cleared when the count falls to the continue level. Between the two levels the bit keeps its value, which gives the loop its hysteresis.

The throttle bit can act on the partner in two ways. With pin signalling enabled, an active-low request-to-send output goes high while throttled. With in-band signalling enabled, each change of the throttle bit raises a request for the transmit path to send a pause (XOFF) or a continue (XON) character. The request stays up until the transmit path acknowledges it. A newer request in the opposite direction overwrites one that has not been sent yet.

Top module: `rx_flow_throttle`

## Requirements
- R1: The pause level is the value of `thr_cfg[3:0]` multiplied by 4 (0 to 60). A count equal to the pause level counts as reaching it, and a count one below does not.
- R2: The continue level is the value of `thr_cfg[7:4]` multiplied by 4 (0 to 60). A count equal to the continue level counts as reaching it, and a count one above does not.
- R3: When `rx_count` is at or above the pause level, the throttle bit sets. With `pin_en` high, `rts_n` is high in the cycle after the count is presented.
- R4: When `rx_count` is at or below the continue level and below the pause level, the throttle bit clears. With `pin_en` high, `rts_n` is low in the cycle after.
- R5: When the count is above the continue level and below the pause level, the throttle bit and `rts_n` keep their previous values.
- R6: When the levels are misordered so that a count meets both conditions, the pause condition wins and the block is throttled.
- R7: With `inband_en` high, every change of the throttle bit raises `chr_req` in the following cycle. `chr_sel` is 1 for XOFF, which is sent on entering the throttled state, and 0 for XON, which is sent on leaving it. The request holds until `chr_ack` is sampled high while `chr_req` is high, and it drops in the cycle after that.
- R8: A state change while a request is still pending replaces it. `chr_req` stays high and `chr_sel` takes the new character.
- R9: After reset the block is not throttled, `rts_n` is 0 and `chr_req` is 0.
- R10: With `pin_en` low, `rts_n` is 0. With `inband_en` low, `chr_req` is 0 in the following cycle and no request is raised. The throttle bit is still tracked, so enabling `pin_en` later makes `rts_n` show the current state one cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_count | input | 7 | Receive buffer occupancy, 0 to 64 |
| thr_cfg | input | 8 | [3:0] pause code, [7:4] continue code, each times 4 |
| pin_en | input | 1 | Enable request-to-send pin signalling |
| inband_en | input | 1 | Enable XOFF/XON character requests |
| chr_ack | input | 1 | Transmit path has taken the pending character |
| rts_n | output | 1 | Active-low request-to-send, high while throttled |
| chr_req | output | 1 | A flow character is waiting to be sent |
| chr_sel | output | 1 | Pending character: 1 = XOFF, 0 = XON |

## Verification
The hardest situation to reach from the ports is a pending XOFF being overwritten by an XON before it is acknowledged. To reach it, the bench raises the count to the pause level with in-band signalling on and holds `chr_ack` low. It then drops the count to the continue level and checks that `chr_req` never fell and that `chr_sel` flipped. The misordered-level case is set up by writing a pause code below the continue code and parking the count between them.

// File: rtl/rx_flow_pkg.sv
package rx_flow_pkg;
  typedef enum logic {
    CHR_XON  = 1'b0,
    CHR_XOFF = 1'b1
  } flow_chr_e;
endpackage

// File: rtl/rx_flow_levels.sv
module rx_flow_levels #(
  parameter int CNT_W    = 7,
  parameter int CODE_W   = 4,
  parameter int SCALE_SH = 2
) (
  input  logic [CNT_W-1:0]    count,
  input  logic [2*CODE_W-1:0] cfg,
  output logic                pause_hit,
  output logic                cont_hit
);
  localparam int LVL_W = CODE_W + SCALE_SH;

  logic [CNT_W-1:0] pause_lvl;
  logic [CNT_W-1:0] cont_lvl;

  always_comb begin
    pause_lvl = CNT_W'({cfg[CODE_W-1:0], {SCALE_SH{1'b0}}});
    cont_lvl  = CNT_W'({cfg[2*CODE_W-1:CODE_W], {SCALE_SH{1'b0}}});
    pause_hit = (count >= pause_lvl);
    cont_hit  = (count <= cont_lvl);
  end

  always_comb begin
    assert (LVL_W <= CNT_W) else $error("level width exceeds count width");
  end
endmodule

// File: rtl/rx_flow_state.sv
module rx_flow_state (
  input  logic clk,
  input  logic rst,
  input  logic pause_hit,
  input  logic cont_hit,
  output logic throttled,
  output logic thr_next,
  output logic changed
);
  always_comb begin
    thr_next = throttled;
    if (pause_hit)     thr_next = 1'b1;
    else if (cont_hit) thr_next = 1'b0;
    changed = (thr_next != throttled);
  end

  always_ff @(posedge clk) begin
    if (rst) throttled <= 1'b0;
    else     throttled <= thr_next;
  end

  AST_PAUSE_SETS: assert property (@(posedge clk) disable iff (rst)
    pause_hit |=> throttled); // R3
  AST_CONT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!pause_hit && cont_hit) |=> !throttled); // R4
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    (!pause_hit && !cont_hit) |=> $stable(throttled)); // R5
endmodule

// File: rtl/rx_flow_chr.sv
module rx_flow_chr
  import rx_flow_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inband_en,
  input  logic      changed,
  input  logic      thr_next,
  input  logic      ack,
  output logic      req,
  output flow_chr_e sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
      sel <= CHR_XON;
    end else if (!inband_en) begin
      req <= 1'b0;
    end else if (changed) begin
      req <= 1'b1;
      sel <= thr_next ? CHR_XOFF : CHR_XON;
    end else if (req && ack) begin
      req <= 1'b0;
    end
  end

  AST_REQ_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (inband_en && changed) |=> req); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (inband_en && req && !ack && !changed) |=> (req && $stable(sel))); // R7
  AST_REPLACE_SEL: assert property (@(posedge clk) disable iff (rst)
    (inband_en && changed && req) |=> (req && sel != $past(sel))); // R8
  AST_NO_REQ_OFF: assert property (@(posedge clk) disable iff (rst)
    !inband_en |=> !req); // R10
endmodule

// File: rtl/rx_flow_throttle.sv
module rx_flow_throttle #(
  parameter int CNT_W    = 7,
  parameter int CODE_W   = 4,
  parameter int SCALE_SH = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CNT_W-1:0]    rx_count,
  input  logic [2*CODE_W-1:0] thr_cfg,
  input  logic                pin_en,
  input  logic                inband_en,
  input  logic                chr_ack,
  output logic                rts_n,
  output logic                chr_req,
  output logic                chr_sel
);
  import rx_flow_pkg::*;

  logic      pause_hit, cont_hit;
  logic      throttled, thr_next, changed;
  flow_chr_e sel_q;

  rx_flow_levels #(.CNT_W(CNT_W), .CODE_W(CODE_W), .SCALE_SH(SCALE_SH)) u_levels (
    .count     (rx_count),
    .cfg       (thr_cfg),
    .pause_hit (pause_hit),
    .cont_hit  (cont_hit)
  );

  rx_flow_state u_state (
    .clk       (clk),
    .rst       (rst),
    .pause_hit (pause_hit),
    .cont_hit  (cont_hit),
    .throttled (throttled),
    .thr_next  (thr_next),
    .changed   (changed)
  );

  rx_flow_chr u_chr (
    .clk       (clk),
    .rst       (rst),
    .inband_en (inband_en),
    .changed   (changed),
    .thr_next  (thr_next),
    .ack       (chr_ack),
    .req       (chr_req),
    .sel       (sel_q)
  );

  assign chr_sel = (sel_q == CHR_XOFF);

  always_ff @(posedge clk) begin
    if (rst) rts_n <= 1'b0;
    else     rts_n <= pin_en & thr_next;
  end

  AST_RTS_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    !pin_en |=> !rts_n); // R10
  AST_RTS_TRACKS: assert property (@(posedge clk) disable iff (rst)
    pin_en |=> (rts_n == throttled)); // R3
  AST_RTS_RESET: assert property (@(posedge clk)
    $past(rst) |-> (!rts_n && !chr_req)); // R9
endmodule

// File: tb/tb_rx_flow_throttle.sv
module tb_rx_flow_throttle;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [6:0] rx_count;
  logic [7:0] thr_cfg;
  logic       pin_en, inband_en, chr_ack;
  logic       rts_n, chr_req, chr_sel;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_flow_throttle dut (
    .clk(clk), .rst(rst), .rx_count(rx_count), .thr_cfg(thr_cfg),
    .pin_en(pin_en), .inband_en(inband_en), .chr_ack(chr_ack),
    .rts_n(rts_n), .chr_req(chr_req), .chr_sel(chr_sel)
  );

  task automatic check(input string tag, input logic e_rts, input logic e_req, input logic e_sel);
    n_checks++;
    if (rts_n !== e_rts || chr_req !== e_req || (e_req && chr_sel !== e_sel)) begin
      n_errors++;
      $display("FAIL %s: rts_n=%b req=%b sel=%b expected rts_n=%b req=%b sel=%b",
               tag, rts_n, chr_req, chr_sel, e_rts, e_req, e_sel);
    end
  endtask

  // Drive on the falling edge, let one rising edge pass, sample on the next falling edge.
  task automatic step(input int cnt, input logic ack, input string tag,
                      input logic e_rts, input logic e_req, input logic e_sel);
    rx_count = 7'(cnt);
    chr_ack  = ack;
    @(negedge clk);
    chr_ack  = 1'b0;
    check(tag, e_rts, e_req, e_sel);
  endtask

  task automatic do_reset();
    rst = 1'b1; rx_count = '0; thr_cfg = 8'h2A; pin_en = 0; inband_en = 0; chr_ack = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R9 reset", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_pin_mode();
    do_reset();
    thr_cfg = 8'h2A; pin_en = 1;          // pause 40, continue 8
    step(39, 0, "R1 below pause", 0, 0, 0);
    step(40, 0, "R1 R3 at pause", 1, 0, 0);
    step(20, 0, "R5 hold throttled", 1, 0, 0);
    step(9,  0, "R2 one above continue", 1, 0, 0);
    step(8,  0, "R2 R4 at continue", 0, 0, 0);
    step(20, 0, "R5 hold released", 0, 0, 0);
    step(64, 0, "R3 full buffer", 1, 0, 0);
  endtask

  task automatic t_inband();
    do_reset();
    thr_cfg = 8'h2A; inband_en = 1;
    step(40, 0, "R7 XOFF raised", 0, 1, 1);
    step(45, 0, "R7 XOFF held", 0, 1, 1);
    step(45, 1, "R7 XOFF acked", 0, 0, 1);
    step(45, 1, "R7 stray ack", 0, 0, 1);
    step(4,  0, "R7 XON raised", 0, 1, 0);
    step(4,  1, "R7 XON acked", 0, 0, 0);
  endtask

  task automatic t_replace();
    do_reset();
    thr_cfg = 8'h2A; inband_en = 1;
    step(50, 0, "R8 XOFF pending", 0, 1, 1);
    step(8,  0, "R8 replaced by XON", 0, 1, 0);
    step(8,  1, "R8 XON acked", 0, 0, 0);
  endtask

  task automatic t_misorder();
    do_reset();
    thr_cfg = 8'hA2; pin_en = 1;          // pause 8, continue 40
    step(20, 0, "R6 both hit pause wins", 1, 0, 0);
    step(4,  0, "R6 continue only", 0, 0, 0);
    step(8,  0, "R6 R1 at pause", 1, 0, 0);
  endtask

  task automatic t_disabled();
    do_reset();
    thr_cfg = 8'h2A;
    step(50, 0, "R10 off, over pause", 0, 0, 0);
    step(20, 0, "R10 off, between", 0, 0, 0);
    pin_en = 1;
    step(20, 0, "R10 state tracked", 1, 0, 0);
    inband_en = 1;
    step(20, 0, "R10 no req without change", 1, 0, 0);
    step(8, 0, "R10 XON after enable", 0, 1, 0);
    inband_en = 0;
    step(8, 0, "R10 req dropped on disable", 0, 0, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_pin_mode();
    t_inband();
    t_replace();
    t_misorder();
    t_disabled();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule